// File: doc/BRIEF.md
# Dual-Alignment PWM Timer Channel

This block is a 16-bit PWM timer with a single output channel. A counter, advanced by a power-of-two clock divider, runs either upward with wrap-around (edge alignment) or upward then downward (center alignment). A channel value is compared against the counter, and each match event updates one internal state flop. The output pin is that flop, optionally inverted. Because the pin follows a flop and not a live comparison, its level survives reconfiguration until the next compare event.

Software writes a period limit, a channel value and a control word through a small write port. The period limit and channel value are double-buffered. They move into the active copies only at a period boundary, or at once while the counter is stopped. The running count is visible on an output. Zero duty, full duty and the values next to the period limit all give clean, steady waveforms.

Top module: `pwm_timer_chan`

## Requirements
- R1: After a synchronous reset the count reads 0, the output state is inactive, the control word is all zero, and `pwm_o` is 0.
- R2: The control word sits at address 2. Bit 0 enables counting, bit 1 selects center alignment, bit 2 inverts the pin, and bits 5:3 hold a divider exponent n. While enabled, the counter advances once every 2^n clock cycles. The first advance comes at the 2^n-th enabled cycle after reset.
- R3: The clock divider is never cleared when n changes. Its next advance comes when the running divider count's low n bits are all ones, so the first interval after a change can be shorter or longer than 2^n.
- R4: In edge alignment the count runs 0,1,…,M and then returns to 0, so one period is M+1 advances. M is the active period limit.
- R5: In center alignment with M>0 the count runs 0,1,…,M,M-1,…,1 and repeats. One period is 2·M advances, and the count moves by exactly one per advance.
- R6: In edge alignment the state becomes active when the count wraps to 0 and inactive when the count reaches the channel value C. The output is active for C advances of each period. C=0 gives 0%, C=M gives M of M+1, and C>M (unsigned) gives 100%.
- R7: In center alignment with positive C, the state is set when the count falls to C and cleared when it rises to C. The output is active for 2·C of 2·M advances. C=M-1 gives 2·M-2 advances, and C≥M gives 100%: for those values the state is set on the turn at the top.
- R8: In center alignment a channel value of 0, or one with bit 15 set, gives 0% duty. The state is cleared when the count returns to 0.
- R9: The period limit (address 0) and channel value (address 1) are written to buffers. While counting, the buffers load into the active copies only at a period boundary: the wrap to 0 in edge alignment, the fall to 0 in center alignment. While the counter is stopped they load on every cycle.
- R10: The output state changes only on a counter advance. Stopping the counter and rewriting the channel value or alignment leaves `pwm_o` unchanged.
- R11: If center counting is stopped with the count at M and then resumed, the next value is M-1. The count never goes above M.
- R12: With the invert bit set, `pwm_o` is the complement of the state. The change takes effect in the cycle after the write.
- R13: With the enable bit clear, the count holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period limit, 1 channel value, 2 control |
| wr_data | input | 16 | Write data |
| count_o | output | 16 | Current counter value |
| pwm_o | output | 1 | PWM pin |

## Verification
The bench measures steady-state duty at both ends of the range and next to the period limit in both alignments. A design that mishandles the values at and just below the limit loses or gains a pulse, or inverts the full-duty case. Negative and zero channel values in center alignment are checked for 0% duty: a design that relies only on compare matches would leave the pin stuck active. Cycle-exact probes target the buffered loads, the divider exponent change and the stop-at-the-top restart. Faults there show up as an early period-limit or duty change, a divider that restarts, or a count that climbs past the limit.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

    localparam int PWMT_CNT_W  = 16;
    localparam int PWMT_PS_W   = 3;
    localparam int PWMT_ADDR_W = 2;
    localparam int PWMT_CTRL_W = PWMT_PS_W + 3;
    localparam int PWMT_DIV_W  = (1 << PWMT_PS_W) - 1;

    typedef enum logic [PWMT_ADDR_W-1:0] {
        REG_LIMIT = 2'd0,
        REG_DUTY  = 2'd1,
        REG_CTRL  = 2'd2
    } reg_sel_e;

    typedef enum logic {
        DIR_UP = 1'b0,
        DIR_DN = 1'b1
    } dir_e;

    typedef struct packed {
        logic [PWMT_PS_W-1:0] ps;
        logic                 inv;
        logic                 center;
        logic                 en;
    } ctrl_t;

    // Description of the step the counter takes on the next advance.
    typedef struct packed {
        logic [PWMT_CNT_W-1:0] nxt;   // value after the advance
        logic                  move;  // the count changes
        logic                  down;  // the change is a decrement
        logic                  bnd;   // the advance closes a period
        logic                  turn;  // decrement that starts at the top
    } step_t;

    function automatic logic [PWMT_DIV_W-1:0] ps_mask(input logic [PWMT_PS_W-1:0] n);
        logic [PWMT_DIV_W:0] one_hot;
        one_hot    = '0;
        one_hot[n] = 1'b1;
        return PWMT_DIV_W'(one_hot - 1'b1);
    endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
    import pwmt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [PWMT_ADDR_W-1:0] wr_addr,
    input  logic [PWMT_CNT_W-1:0]  wr_data,
    input  logic                   load,
    output ctrl_t                  ctrl,
    output logic [PWMT_CNT_W-1:0]  duty_buf,
    output logic [PWMT_CNT_W-1:0]  limit_act,
    output logic [PWMT_CNT_W-1:0]  duty_act
);

    logic [PWMT_CNT_W-1:0] limit_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            limit_buf <= '0;
            duty_buf  <= '0;
            limit_act <= '0;
            duty_act  <= '0;
        end else begin
            if (wr_en) begin
                case (reg_sel_e'(wr_addr))
                    REG_LIMIT: limit_buf <= wr_data;
                    REG_DUTY:  duty_buf  <= wr_data;
                    REG_CTRL:  ctrl      <= ctrl_t'(wr_data[PWMT_CTRL_W-1:0]);
                    default:   ;
                endcase
            end
            if (load) begin
                limit_act <= limit_buf;
                duty_act  <= duty_buf;
            end
        end
    end

endmodule

// File: rtl/pwmt_prescaler.sv
module pwmt_prescaler
    import pwmt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic [PWMT_PS_W-1:0] ps,
    output logic                 tick
);

    logic [PWMT_DIV_W-1:0] div_q;
    logic [PWMT_DIV_W-1:0] mask;

    assign mask = ps_mask(ps);
    assign tick = en && ((div_q & mask) == mask);

    // The divider is only cleared by reset, never by a change of ps.
    always_ff @(posedge clk) begin
        if (rst)
            div_q <= '0;
        else if (en)
            div_q <= div_q + 1'b1;
    end

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter
    import pwmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  center,
    input  logic [PWMT_CNT_W-1:0] limit,
    output logic [PWMT_CNT_W-1:0] cnt,
    output step_t                 step
);

    dir_e dir_q;
    dir_e dir_d;

    always_comb begin
        step     = '0;
        step.nxt = cnt;
        dir_d    = dir_q;
        if (!center) begin
            dir_d     = DIR_UP;
            step.move = 1'b1;
            if (cnt >= limit) begin
                step.nxt = '0;
                step.bnd = 1'b1;
            end else begin
                step.nxt = cnt + 1'b1;
            end
        end else if (limit == '0) begin
            step.nxt = '0;
            step.bnd = 1'b1;
            dir_d    = DIR_UP;
        end else begin
            step.move = 1'b1;
            if (dir_q == DIR_UP && cnt < limit) begin
                step.nxt = cnt + 1'b1;
            end else if (dir_q == DIR_DN && cnt == '0) begin
                step.nxt = PWMT_CNT_W'(1);
                dir_d    = DIR_UP;
            end else begin
                // Either turning at the top or continuing downward.
                step.down = 1'b1;
                step.turn = (dir_q == DIR_UP);
                step.nxt  = cnt - 1'b1;
                dir_d     = DIR_DN;
                if (cnt == PWMT_CNT_W'(1)) begin
                    step.bnd = 1'b1;
                    dir_d    = DIR_UP;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            dir_q <= DIR_UP;
        end else if (tick) begin
            cnt   <= step.nxt;
            dir_q <= dir_d;
        end
    end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
    import pwmt_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic                  center,
    input  logic                  inv,
    input  step_t                 step,
    input  logic [PWMT_CNT_W-1:0] limit,
    input  logic [PWMT_CNT_W-1:0] duty,
    output logic                  act_q,
    output logic                  pin
);

    logic neg;
    logic zero;
    logic hit;
    logic set_c;
    logic clr_c;

    always_comb begin
        neg   = duty[PWMT_CNT_W-1];
        zero  = (duty == '0);
        hit   = (step.nxt == duty);
        set_c = 1'b0;
        clr_c = 1'b0;
        if (!center) begin
            if (step.bnd) begin
                set_c = !zero;
                clr_c = zero;
            end else begin
                clr_c = hit;
            end
        end else if (step.move) begin
            if (step.down) begin
                if (neg || zero)
                    clr_c = step.bnd;
                else
                    set_c = hit || (step.turn && duty >= limit);
            end else begin
                clr_c = !neg && (duty < limit) && hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            act_q <= 1'b0;
        else if (tick) begin
            if (clr_c)
                act_q <= 1'b0;
            else if (set_c)
                act_q <= 1'b1;
        end
    end

    assign pin = act_q ^ inv;

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwmt_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [PWMT_ADDR_W-1:0] wr_addr,
    input  logic [PWMT_CNT_W-1:0]  wr_data,
    output logic [PWMT_CNT_W-1:0]  count_o,
    output logic                   pwm_o
);

    ctrl_t                 ctrl_q;
    logic [PWMT_CNT_W-1:0] duty_buf_q;
    logic [PWMT_CNT_W-1:0] limit_act_q;
    logic [PWMT_CNT_W-1:0] duty_act_q;
    logic [PWMT_CNT_W-1:0] duty_eff;
    logic [PWMT_CNT_W-1:0] cnt_w;
    logic                  tick_w;
    logic                  load_w;
    logic                  edge_load;
    logic                  act_w;
    step_t                 step_w;

    assign edge_load = tick_w && step_w.bnd;
    assign load_w    = !ctrl_q.en || edge_load;
    assign duty_eff  = edge_load ? duty_buf_q : duty_act_q;

    pwmt_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .load      (load_w),
        .ctrl      (ctrl_q),
        .duty_buf  (duty_buf_q),
        .limit_act (limit_act_q),
        .duty_act  (duty_act_q)
    );

    pwmt_prescaler u_div (
        .clk  (clk),
        .rst  (rst),
        .en   (ctrl_q.en),
        .ps   (ctrl_q.ps),
        .tick (tick_w)
    );

    pwmt_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_w),
        .center (ctrl_q.center),
        .limit  (limit_act_q),
        .cnt    (cnt_w),
        .step   (step_w)
    );

    pwmt_channel u_chan (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_w),
        .center (ctrl_q.center),
        .inv    (ctrl_q.inv),
        .step   (step_w),
        .limit  (limit_act_q),
        .duty   (duty_eff),
        .act_q  (act_w),
        .pin    (pwm_o)
    );

    assign count_o = cnt_w;

endmodule

// File: rtl/pwmt_checker.sv
module pwmt_checker
    import pwmt_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  en,
    input logic                  center,
    input logic [PWMT_PS_W-1:0]  ps,
    input logic                  tick,
    input logic [PWMT_CNT_W-1:0] cnt,
    input logic [PWMT_CNT_W-1:0] limit,
    input logic                  act
);

    AST_FULL_RATE_TICK: assert property (@(posedge clk) disable iff (rst)
        (en && ps == '0) |-> tick); // R2

    AST_EDGE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick && !center && cnt >= limit) |=> (cnt == '0)); // R4

    AST_CENTER_UNIT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && center && limit != '0) |=> (cnt == $past(cnt) + 1 || cnt == $past(cnt) - 1)); // R5

    AST_STATE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act)); // R10

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt <= limit) |=> (cnt <= $past(limit))); // R11

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt)); // R13

endmodule

bind pwm_timer_chan pwmt_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .en     (ctrl_q.en),
    .center (ctrl_q.center),
    .ps     (ctrl_q.ps),
    .tick   (tick_w),
    .cnt    (cnt_w),
    .limit  (limit_act_q),
    .act    (act_w)
);

// File: tb/sim_pwm_timer_chan.sv
module sim_pwm_timer_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] count_o;
    logic        pwm_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwm_timer_chan u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .count_o (count_o),
        .pwm_o   (pwm_o)
    );

    typedef struct packed {
        logic        center;
        logic        inv;
        logic [2:0]  ps;
        logic [15:0] lim;
        logic [15:0] duty;
        logic [15:0] act;   // expected active advances per period
    } vec_t;

    localparam int NVEC = 11;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 3'd0, 16'd9, 16'd4,      16'd4},
        '{1'b0, 1'b0, 3'd0, 16'd9, 16'd0,      16'd0},
        '{1'b0, 1'b0, 3'd0, 16'd9, 16'd9,      16'd9},
        '{1'b0, 1'b0, 3'd0, 16'd9, 16'd10,     16'd10},
        '{1'b1, 1'b0, 3'd0, 16'd8, 16'd3,      16'd6},
        '{1'b1, 1'b0, 3'd0, 16'd8, 16'd8,      16'd16},
        '{1'b1, 1'b0, 3'd0, 16'd8, 16'd7,      16'd14},
        '{1'b1, 1'b0, 3'd0, 16'd8, 16'hFFFE,   16'd0},
        '{1'b1, 1'b0, 3'd0, 16'd8, 16'd0,      16'd0},
        '{1'b1, 1'b1, 3'd2, 16'd5, 16'd2,      16'd4},
        '{1'b0, 1'b1, 3'd1, 16'd7, 16'd3,      16'd3}
    };

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        vec_t  cur;
        int    period;
        int    cyc;
        int    hits;
        string tag;

        // Duty table walk: R6, R7, R8, R12
        for (int v = 0; v < NVEC; v++) begin
            cur    = VECS[v];
            period = cur.center ? 2 * int'(cur.lim) : int'(cur.lim) + 1;
            cyc    = period << cur.ps;
            if (cur.inv)
                tag = "R12";
            else if (!cur.center)
                tag = "R6";
            else if (cur.duty == 16'd0 || cur.duty[15])
                tag = "R8";
            else
                tag = "R7";
            do_reset();
            wr(2'd0, cur.lim);
            wr(2'd1, cur.duty);
            wr(2'd2, {10'd0, cur.ps, cur.inv, cur.center, 1'b1});
            wait_n(3 * cyc);
            hits = 0;
            for (int k = 0; k < cyc; k++) begin
                if (pwm_o == !cur.inv) hits++;
                @(negedge clk);
            end
            chk(hits, int'(cur.act) << cur.ps, tag);
        end

        // R1: reset state
        do_reset();
        chk(int'(count_o), 0, "R1 count");
        chk(int'(pwm_o), 0, "R1 pin");

        // R2: divide by 4 from reset
        wr(2'd0, 16'd100);
        wr(2'd2, 16'h0011);          // en, n=2
        wait_n(3);
        chk(int'(count_o), 0, "R2 before first advance");
        wait_n(1);
        chk(int'(count_o), 1, "R2 first advance");
        wait_n(4);
        chk(int'(count_o), 2, "R2 second advance");

        // R3: exponent change keeps divider phase
        do_reset();
        wr(2'd0, 16'd100);
        wr(2'd2, 16'h0019);          // en, n=3
        wait_n(2);
        wr(2'd2, 16'h0011);          // en, n=2
        chk(int'(count_o), 0, "R3 no advance yet");
        wait_n(1);
        chk(int'(count_o), 1, "R3 short first interval");

        // R5: center count sequence, limit 3
        do_reset();
        wr(2'd0, 16'd3);
        wr(2'd2, 16'h0003);          // en, center
        for (int k = 0; k < 8; k++) begin
            int seq [8] = '{1, 2, 3, 2, 1, 0, 1, 2};
            wait_n(1);
            chk(int'(count_o), seq[k], "R5 sequence");
        end

        // R9 / R4: buffered period limit
        do_reset();
        wr(2'd0, 16'd9);
        wr(2'd2, 16'h0001);
        wait_n(3);
        wr(2'd0, 16'd4);
        wait_n(5);
        chk(int'(count_o), 9, "R9 old limit still active");
        wait_n(1);
        chk(int'(count_o), 0, "R4 wrap at limit");
        wait_n(4);
        chk(int'(count_o), 4, "R9 new limit top");
        wait_n(1);
        chk(int'(count_o), 0, "R9 new limit wrap");

        // R9: buffered channel value
        do_reset();
        wr(2'd0, 16'd9);
        wr(2'd1, 16'd8);
        wr(2'd2, 16'h0001);
        wait_n(13);
        wr(2'd1, 16'd2);
        wait_n(3);
        chk(int'(pwm_o), 1, "R9 active before old match");
        wait_n(1);
        chk(int'(pwm_o), 0, "R9 old value still governs");
        wait_n(3);
        chk(int'(pwm_o), 1, "R6 set at wrap");
        wait_n(1);
        chk(int'(pwm_o), 0, "R9 new value governs next period");

        // R11 / R13: stop at the top and resume
        do_reset();
        wr(2'd0, 16'd3);
        wr(2'd2, 16'h0003);
        wait_n(2);
        wr(2'd2, 16'h0002);          // stop, keep center
        chk(int'(count_o), 3, "R11 stopped at top");
        wait_n(3);
        chk(int'(count_o), 3, "R13 held while stopped");
        wr(2'd2, 16'h0003);
        chk(int'(count_o), 3, "R13 no advance on restart edge");
        wait_n(1);
        chk(int'(count_o), 2, "R11 resumes downward");
        wait_n(1);
        chk(int'(count_o), 1, "R11 continues downward");

        // R10 / R12: state persists across reconfiguration
        do_reset();
        wr(2'd0, 16'd9);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'h0001);
        wait_n(11);
        chk(int'(pwm_o), 1, "R10 active after wrap");
        wr(2'd2, 16'h0000);          // stop
        wr(2'd1, 16'd0);
        wr(2'd2, 16'h0002);          // center, still stopped
        wait_n(3);
        chk(int'(pwm_o), 1, "R10 state kept after reconfiguration");
        chk(int'(count_o), 2, "R13 count kept while stopped");
        wr(2'd2, 16'h0006);          // invert, still stopped
        chk(int'(pwm_o), 0, "R12 inverted pin");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule